// File: doc/BRIEF.md
# Vector Shape Configuration Unit

This unit performs the setup step of a shape-configuration instruction for a vector engine. A single `start` pulse supplies three 5-bit encoded dimensions (x, y, z), a 4-bit schedule code, a vertical-first flag, the current persistence bit and the current operand-remap selector and enable bits. The unit computes a vector length and a maximum vector length, then writes four 32-bit shape words that later index generators decode. It also writes the updated state bits. Three schedules are supported: matrix multiply, FFT butterfly and parallel tree reduction. Any other code yields empty shapes and a zero length.

The vector length is computed in a different way for each schedule. Matrix mode uses a product of the three dimensions. FFT mode scales the length by the number of trailing ones in the x field, found by a bit scan. Reduction mode counts the operations of the reduction tree by walking it. The scan and the tree walk each take one cycle per step, so the unit runs as a small state machine. Its states are IDLE, LAUNCH, COUNT, SCALE and COMMIT, and it moves through them as follows:
- IDLE to LAUNCH when `start` is high.
- LAUNCH to COUNT for the FFT and reduction schedules, and LAUNCH to SCALE for all other codes.
- COUNT to SCALE when the scan or the tree walk reports completion.
- SCALE to COMMIT, and COMMIT to IDLE, unconditionally.

Every result register loads on the COMMIT edge, so all outputs change together in the single cycle in which `done` is high.

Top module: `shp_cfg_unit`

## Requirements
- R1: After reset all shape words, `vl`, `maxvl`, `vf_out`, `persist_out`, `remap_sel_out`, `remap_en_out`, `busy` and `done` are zero.
- R2: Schedule code 4'b0000 (matrix) sets `vl` to (x+1)*(y+1)*(z+1) modulo 128 and sets `maxvl` equal to `vl`.
- R3: Shape words are packed MSB-first: x dim at [31:26], y dim at [25:20], z dim at [19:14], permute at [13:11], zeros at [10:4], skip at [3:2] and mode at [1:0]. Each dim field holds the encoded field zero-extended to 6 bits. In matrix mode, shape 0 and shape 3 carry x, y and z with skip 2'b11, permute 3'b000 and mode 2'b00. Shape 1 carries the same dims with permute 3'b001 and skip 2'b01. Shape 2 carries the same dims with permute 3'b001 and skip 2'b11.
- R4: Schedule code 4'b0001 (FFT) sets `vl` to (x+1)*k modulo 128. Here k is the number of consecutive ones in x counted upward from bit 0, at most 5.
- R5: In FFT mode, shape 0 carries x and z with y dim 0, skip 2'b00 and mode 2'b01. Shape 1 equals shape 0 except skip 2'b01. Shape 2 equals shape 0 except skip 2'b10. Shape 3 is zero.
- R6: Schedule code 4'b0111 (reduction) sets `vl` to the operation count of a pairwise tree over x+1 leaves, with stride doubling each level. Shape 0 carries x and z with skip 2'b00 and mode 2'b10. Shape 1 equals shape 0 except skip 2'b01. Shapes 2 and 3 are zero.
- R7: In FFT and reduction modes, `maxvl` is `vl`*(z+1) modulo 128.
- R8: Any other schedule code gives all four shape words zero, `vl` zero and `maxvl` zero.
- R9: `vf_out` takes the vertical-first flag and `persist_out` takes the persistence bit sampled at `start`.
- R10: When the sampled persistence bit is 0, `remap_sel_out` and `remap_en_out` become zero. When it is 1, they take the values sampled at `start`.
- R11: `done` is a single-cycle pulse, and every result output changes only in a cycle where `done` is high. `busy` is high from the cycle after an accepted `start` until the cycle in which `done` is high, when it falls.
- R12: A `start` while `busy` is high is ignored. The inputs sampled at the accepted `start` alone determine the results, even if the inputs change later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a configuration (accepted only when idle) |
| x_fld | input | 5 | Encoded x dimension |
| y_fld | input | 5 | Encoded y dimension |
| z_fld | input | 5 | Encoded z dimension / stride |
| sched | input | 4 | Schedule code |
| vf_in | input | 1 | Vertical-first flag |
| persist_in | input | 1 | Current persistence bit |
| remap_sel_in | input | 10 | Current operand shape selectors |
| remap_en_in | input | 5 | Current operand remap enables |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion strobe |
| shape0 | output | 32 | Shape word 0 |
| shape1 | output | 32 | Shape word 1 |
| shape2 | output | 32 | Shape word 2 |
| shape3 | output | 32 | Shape word 3 |
| vl | output | 7 | Vector length |
| maxvl | output | 7 | Maximum vector length |
| vf_out | output | 1 | Stored vertical-first flag |
| persist_out | output | 1 | Stored persistence bit |
| remap_sel_out | output | 10 | Updated operand shape selectors |
| remap_en_out | output | 5 | Updated operand remap enables |

## Verification
A wrong latched schedule code or dimension shows at the ports at the next `done`, as wrong shape fields or a wrong length. Every output is compared on every clock, so the error is caught in that same cycle. A scan counter or tree walker that stops early or runs on shows up as a wrong `vl` and `maxvl` at the commit. If it never completes, `done` never arrives, which the per-run timeout reports. A state machine that commits twice, commits without a start, or lets outputs move outside the `done` cycle is caught in the first cycle where an output differs from the last committed value.

// File: rtl/shp_pkg.sv
package shp_pkg;

    localparam int SHAPE_CNT = 4;

    localparam logic [3:0] SCH_MATRIX = 4'b0000;
    localparam logic [3:0] SCH_FFT    = 4'b0001;
    localparam logic [3:0] SCH_REDUCE = 4'b0111;

    localparam logic [1:0] KIND_MATRIX = 2'b00;
    localparam logic [1:0] KIND_BFLY   = 2'b01;
    localparam logic [1:0] KIND_TREE   = 2'b10;

    // First member is the most significant: matches MSB-first field numbering.
    typedef struct packed {
        logic [5:0] dx;
        logic [5:0] dy;
        logic [5:0] dz;
        logic [2:0] perm;
        logic [2:0] inv;
        logic [3:0] offs;
        logic [1:0] skip;
        logic [1:0] kind;
    } shape_word_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LAUNCH,
        ST_COUNT,
        ST_SCALE,
        ST_COMMIT
    } cfg_state_e;

    typedef enum logic {
        SC_IDLE,
        SC_SCAN
    } scan_state_e;

    typedef enum logic [1:0] {
        RC_IDLE,
        RC_OUTER,
        RC_INNER
    } red_state_e;

endpackage

// File: rtl/shp_template.sv
module shp_template
    import shp_pkg::*;
#(
    parameter int DIM_W  = 5,
    parameter int SHAPES = SHAPE_CNT
) (
    input  logic [3:0]       sched,
    input  logic [DIM_W-1:0] xf,
    input  logic [DIM_W-1:0] yf,
    input  logic [DIM_W-1:0] zf,
    output logic [31:0]      shape_o [SHAPES]
);

    shape_word_t base;

    always_comb begin
        base    = '0;
        base.dx = 6'(xf);
        base.dz = 6'(zf);
        case (sched)
            SCH_MATRIX: begin
                base.dy   = 6'(yf);
                base.skip = 2'b11;
                base.kind = KIND_MATRIX;
            end
            SCH_FFT:    base.kind = KIND_BFLY;
            SCH_REDUCE: base.kind = KIND_TREE;
            default:    base = '0;
        endcase
    end

    for (genvar g = 0; g < SHAPES; g++) begin : g_shape
        shape_word_t w;
        always_comb begin
            w = base;
            case (sched)
                SCH_MATRIX: begin
                    if (g == 1) begin
                        w.perm = 3'b001;
                        w.skip = 2'b01;
                    end else if (g == 2) begin
                        w.perm = 3'b001;
                        w.skip = 2'b11;
                    end
                end
                SCH_FFT: begin
                    if (g == 1)      w.skip = 2'b01;
                    else if (g == 2) w.skip = 2'b10;
                    else if (g >= 3) w = '0;
                end
                SCH_REDUCE: begin
                    if (g == 1)      w.skip = 2'b01;
                    else if (g >= 2) w = '0;
                end
                default: w = '0;
            endcase
        end
        assign shape_o[g] = w;
    end

endmodule

// File: rtl/shp_runscan.sv
module shp_runscan
    import shp_pkg::*;
#(
    parameter int DIM_W = 5,
    parameter int CAP   = 5,
    localparam int PW   = $clog2(CAP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [DIM_W-1:0] field,
    output logic             done,
    output logic [PW-1:0]    count
);

    scan_state_e      st;
    logic [DIM_W-1:0] shifted;
    logic             bit_now;

    always_comb begin
        shifted = field >> count;
        bit_now = shifted[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= SC_IDLE;
            done  <= 1'b0;
            count <= '0;
        end else begin
            unique case (st)
                SC_IDLE: begin
                    done <= 1'b0;
                    if (go) begin
                        count <= '0;
                        st    <= SC_SCAN;
                    end
                end
                SC_SCAN: begin
                    if ((count < PW'(CAP)) && bit_now) begin
                        count <= count + 1'b1;
                    end else begin
                        done <= 1'b1;
                        st   <= SC_IDLE;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/shp_redcount.sv
module shp_redcount
    import shp_pkg::*;
#(
    parameter int CNT_W = 6,
    localparam int SW   = CNT_W + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [CNT_W-1:0] leaves,
    output logic             done,
    output logic [CNT_W-1:0] ops
);

    red_state_e    st;
    logic [SW-1:0] step;
    logic [SW-1:0] pos;
    logic [SW-1:0] lim;

    assign lim = SW'(leaves);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= RC_IDLE;
            done <= 1'b0;
            ops  <= '0;
            step <= '0;
            pos  <= '0;
        end else begin
            unique case (st)
                RC_IDLE: begin
                    done <= 1'b0;
                    if (go) begin
                        step <= SW'(1);
                        pos  <= '0;
                        ops  <= '0;
                        st   <= RC_OUTER;
                    end
                end
                RC_OUTER: begin
                    if (step < lim) begin
                        pos <= '0;
                        st  <= RC_INNER;
                    end else begin
                        done <= 1'b1;
                        st   <= RC_IDLE;
                    end
                end
                RC_INNER: begin
                    if ((pos + step) < lim) begin
                        pos <= pos + (step << 1);
                        ops <= ops + 1'b1;
                    end else begin
                        step <= step << 1;
                        st   <= RC_OUTER;
                    end
                end
                default: st <= RC_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/shp_cfg_unit.sv
module shp_cfg_unit
    import shp_pkg::*;
#(
    parameter int DIM_W    = 5,
    parameter int VL_W     = 7,
    parameter int FFT_CAP  = 5,
    parameter int OPERANDS = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [DIM_W-1:0]        x_fld,
    input  logic [DIM_W-1:0]        y_fld,
    input  logic [DIM_W-1:0]        z_fld,
    input  logic [3:0]              sched,
    input  logic                    vf_in,
    input  logic                    persist_in,
    input  logic [2*OPERANDS-1:0]   remap_sel_in,
    input  logic [OPERANDS-1:0]     remap_en_in,
    output logic                    busy,
    output logic                    done,
    output logic [31:0]             shape0,
    output logic [31:0]             shape1,
    output logic [31:0]             shape2,
    output logic [31:0]             shape3,
    output logic [VL_W-1:0]         vl,
    output logic [VL_W-1:0]         maxvl,
    output logic                    vf_out,
    output logic                    persist_out,
    output logic [2*OPERANDS-1:0]   remap_sel_out,
    output logic [OPERANDS-1:0]     remap_en_out
);

    localparam int FW  = DIM_W + 1;
    localparam int SCW = $clog2(FFT_CAP + 1);
    localparam int MPW = 3 * FW;
    localparam int FPW = FW + SCW;
    localparam int SPW = VL_W + FW;
    localparam int SEL_W = 2 * OPERANDS;

    cfg_state_e state, state_nx;

    logic [DIM_W-1:0] x_q, y_q, z_q;
    logic [3:0]       sched_q;
    logic             vf_q, pers_q;
    logic [SEL_W-1:0] sel_q;
    logic [OPERANDS-1:0] en_q;
    logic [VL_W-1:0]  vl_acc, maxvl_acc;

    logic [FW-1:0]  xd, yd, zd;
    logic [MPW-1:0] mat_prod;
    logic [FPW-1:0] fft_prod;
    logic [SPW-1:0] scaled;

    logic           scan_go, scan_done;
    logic [SCW-1:0] scan_cnt;
    logic           red_go, red_done;
    logic [FW-1:0]  red_ops;
    logic [31:0]    tmpl [SHAPE_CNT];

    logic is_fft, is_red, is_mat;

    assign is_fft = (sched_q == SCH_FFT);
    assign is_red = (sched_q == SCH_REDUCE);
    assign is_mat = (sched_q == SCH_MATRIX);

    assign xd = {1'b0, x_q} + FW'(1);
    assign yd = {1'b0, y_q} + FW'(1);
    assign zd = {1'b0, z_q} + FW'(1);

    assign mat_prod = MPW'(xd) * MPW'(yd) * MPW'(zd);
    assign fft_prod = FPW'(xd) * FPW'(scan_cnt);
    assign scaled   = SPW'(vl_acc) * SPW'(zd);

    assign scan_go = (state == ST_LAUNCH) && is_fft;
    assign red_go  = (state == ST_LAUNCH) && is_red;
    assign busy    = (state != ST_IDLE);

    shp_template #(.DIM_W(DIM_W), .SHAPES(SHAPE_CNT)) u_tmpl (
        .sched   (sched_q),
        .xf      (x_q),
        .yf      (y_q),
        .zf      (z_q),
        .shape_o (tmpl)
    );

    shp_runscan #(.DIM_W(DIM_W), .CAP(FFT_CAP)) u_scan (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (scan_go),
        .field (x_q),
        .done  (scan_done),
        .count (scan_cnt)
    );

    shp_redcount #(.CNT_W(FW)) u_red (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (red_go),
        .leaves (xd),
        .done   (red_done),
        .ops    (red_ops)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_LAUNCH;
            ST_LAUNCH: state_nx = (is_fft || is_red) ? ST_COUNT : ST_SCALE;
            ST_COUNT:  if ((is_fft && scan_done) || (is_red && red_done))
                           state_nx = ST_SCALE;
            ST_SCALE:  state_nx = ST_COMMIT;
            ST_COMMIT: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            x_q           <= '0;
            y_q           <= '0;
            z_q           <= '0;
            sched_q       <= '0;
            vf_q          <= 1'b0;
            pers_q        <= 1'b0;
            sel_q         <= '0;
            en_q          <= '0;
            vl_acc        <= '0;
            maxvl_acc     <= '0;
            done          <= 1'b0;
            shape0        <= '0;
            shape1        <= '0;
            shape2        <= '0;
            shape3        <= '0;
            vl            <= '0;
            maxvl         <= '0;
            vf_out        <= 1'b0;
            persist_out   <= 1'b0;
            remap_sel_out <= '0;
            remap_en_out  <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        x_q     <= x_fld;
                        y_q     <= y_fld;
                        z_q     <= z_fld;
                        sched_q <= sched;
                        vf_q    <= vf_in;
                        pers_q  <= persist_in;
                        sel_q   <= remap_sel_in;
                        en_q    <= remap_en_in;
                    end
                end
                ST_LAUNCH: begin
                    if (is_mat)                vl_acc <= mat_prod[VL_W-1:0];
                    else if (!is_fft && !is_red) vl_acc <= '0;
                end
                ST_COUNT: begin
                    if (is_fft && scan_done) vl_acc <= fft_prod[VL_W-1:0];
                    if (is_red && red_done)  vl_acc <= VL_W'(red_ops);
                end
                ST_SCALE: begin
                    maxvl_acc <= is_mat ? vl_acc : scaled[VL_W-1:0];
                end
                ST_COMMIT: begin
                    done          <= 1'b1;
                    shape0        <= tmpl[0];
                    shape1        <= tmpl[1];
                    shape2        <= tmpl[2];
                    shape3        <= tmpl[3];
                    vl            <= vl_acc;
                    maxvl         <= maxvl_acc;
                    vf_out        <= vf_q;
                    persist_out   <= pers_q;
                    remap_sel_out <= pers_q ? sel_q : '0;
                    remap_en_out  <= pers_q ? en_q  : '0;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/shp_cfg_chk.sv
module shp_cfg_chk
    import shp_pkg::*;
#(
    parameter int VL_W  = 7,
    parameter int SEL_W = 10,
    parameter int EN_W  = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic [31:0]      shape0,
    input logic [31:0]      shape1,
    input logic [31:0]      shape2,
    input logic [31:0]      shape3,
    input logic [VL_W-1:0]  vl,
    input logic [VL_W-1:0]  maxvl,
    input logic             persist_out,
    input logic [SEL_W-1:0] remap_sel_out,
    input logic [EN_W-1:0]  remap_en_out,
    input logic [3:0]       sched_q
);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(vl) && $stable(maxvl) && $stable(shape0) &&
                   $stable(shape1) && $stable(shape2) && $stable(shape3)));

    // R12
    busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    // R11
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(busy) && !busy));

    // R2
    mat_maxvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && sched_q == SCH_MATRIX) |-> (maxvl == vl));

    // R8
    unsup_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && sched_q != SCH_MATRIX && sched_q != SCH_FFT && sched_q != SCH_REDUCE)
        |-> (vl == '0 && maxvl == '0 && shape0 == '0 && shape1 == '0 &&
             shape2 == '0 && shape3 == '0));

    // R10
    clear_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !persist_out) |-> (remap_sel_out == '0 && remap_en_out == '0));

endmodule

bind shp_cfg_unit shp_cfg_chk #(
    .VL_W  (VL_W),
    .SEL_W (2 * OPERANDS),
    .EN_W  (OPERANDS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .busy          (busy),
    .done          (done),
    .shape0        (shape0),
    .shape1        (shape1),
    .shape2        (shape2),
    .shape3        (shape3),
    .vl            (vl),
    .maxvl         (maxvl),
    .persist_out   (persist_out),
    .remap_sel_out (remap_sel_out),
    .remap_en_out  (remap_en_out),
    .sched_q       (sched_q)
);

// File: tb/sim_shp_cfg_unit.sv
`timescale 1ns/1ps
module sim_shp_cfg_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [4:0]  x_fld = '0, y_fld = '0, z_fld = '0;
    logic [3:0]  sched = '0;
    logic        vf_in = 1'b0, persist_in = 1'b0;
    logic [9:0]  remap_sel_in = '0;
    logic [4:0]  remap_en_in = '0;
    logic        busy, done;
    logic [31:0] shape0, shape1, shape2, shape3;
    logic [6:0]  vl, maxvl;
    logic        vf_out, persist_out;
    logic [9:0]  remap_sel_out;
    logic [4:0]  remap_en_out;

    int nchk = 0;
    int nbad = 0;
    int commits = 0;

    // committed (c_) and pending (p_) model state
    logic [31:0] c_sh [4];
    logic [31:0] p_sh [4];
    logic [6:0]  c_vl = '0, p_vl, c_mx = '0, p_mx;
    logic        c_vf = 0, p_vf, c_ps = 0, p_ps;
    logic [9:0]  c_sel = '0, p_sel;
    logic [4:0]  c_en = '0, p_en;
    bit          pend = 0;
    bit          prev_done = 0;

    always #2.5 clk = ~clk;

    shp_cfg_unit u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .x_fld(x_fld), .y_fld(y_fld), .z_fld(z_fld), .sched(sched),
        .vf_in(vf_in), .persist_in(persist_in),
        .remap_sel_in(remap_sel_in), .remap_en_in(remap_en_in),
        .busy(busy), .done(done),
        .shape0(shape0), .shape1(shape1), .shape2(shape2), .shape3(shape3),
        .vl(vl), .maxvl(maxvl), .vf_out(vf_out), .persist_out(persist_out),
        .remap_sel_out(remap_sel_out), .remap_en_out(remap_en_out)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(int dx, int dy, int dz, int perm, int skip, int kind);
        return {6'(dx), 6'(dy), 6'(dz), 3'(perm), 3'b000, 4'b0000, 2'(skip), 2'(kind)};
    endfunction

    function automatic int trail_ones(int x);
        int k = 0;
        while (k < 5 && ((x >> k) & 1) == 1) k++;
        return k;
    endfunction

    function automatic int tree_ops(int leaves);
        int ops = 0;
        for (int step = 1; step < leaves; step = step * 2)
            for (int j = 0; j + step < leaves; j = j + 2 * step) ops++;
        return ops;
    endfunction

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                if (!pend) begin
                    nchk++; nbad++;
                    $display("FAIL R11 done without start actual=1 expected=0");
                end else begin
                    for (int i = 0; i < 4; i++) c_sh[i] = p_sh[i];
                    c_vl = p_vl; c_mx = p_mx; c_vf = p_vf; c_ps = p_ps;
                    c_sel = p_sel; c_en = p_en;
                    pend = 0;
                    commits++;
                end
            end
            if (done && prev_done) chk("R11 done width", 32'(done), 32'd0);
            chk("R3 R5 R6 R8 shape0", shape0, c_sh[0]);
            chk("R3 R5 R6 R8 shape1", shape1, c_sh[1]);
            chk("R3 R5 R6 R8 shape2", shape2, c_sh[2]);
            chk("R3 R5 R6 R8 shape3", shape3, c_sh[3]);
            chk("R2 R4 R6 vl", 32'(vl), 32'(c_vl));
            chk("R2 R7 maxvl", 32'(maxvl), 32'(c_mx));
            chk("R9 vf_out", 32'(vf_out), 32'(c_vf));
            chk("R9 persist_out", 32'(persist_out), 32'(c_ps));
            chk("R10 remap_sel_out", 32'(remap_sel_out), 32'(c_sel));
            chk("R10 remap_en_out", 32'(remap_en_out), 32'(c_en));
            prev_done = done;
        end
    end

    task automatic run(int x, int y, int z, logic [3:0] s, bit vf, bit ps,
                       logic [9:0] sel, logic [4:0] en, bit glitch);
        int c0;
        int v;
        case (s)
            4'b0000: begin
                v = ((x + 1) * (y + 1) * (z + 1)) % 128;
                p_vl = 7'(v); p_mx = 7'(v);
                p_sh[0] = mk(x, y, z, 0, 3, 0);
                p_sh[1] = mk(x, y, z, 1, 1, 0);
                p_sh[2] = mk(x, y, z, 1, 3, 0);
                p_sh[3] = p_sh[0];
            end
            4'b0001: begin
                v = ((x + 1) * trail_ones(x)) % 128;
                p_vl = 7'(v); p_mx = 7'((v * (z + 1)) % 128);
                p_sh[0] = mk(x, 0, z, 0, 0, 1);
                p_sh[1] = mk(x, 0, z, 0, 1, 1);
                p_sh[2] = mk(x, 0, z, 0, 2, 1);
                p_sh[3] = '0;
            end
            4'b0111: begin
                v = tree_ops(x + 1) % 128;
                p_vl = 7'(v); p_mx = 7'((v * (z + 1)) % 128);
                p_sh[0] = mk(x, 0, z, 0, 0, 2);
                p_sh[1] = mk(x, 0, z, 0, 1, 2);
                p_sh[2] = '0;
                p_sh[3] = '0;
            end
            default: begin
                p_vl = '0; p_mx = '0;
                for (int i = 0; i < 4; i++) p_sh[i] = '0;
            end
        endcase
        p_vf = vf; p_ps = ps;
        p_sel = ps ? sel : '0;
        p_en  = ps ? en  : '0;
        c0 = commits;
        x_fld = 5'(x); y_fld = 5'(y); z_fld = 5'(z); sched = s;
        vf_in = vf; persist_in = ps; remap_sel_in = sel; remap_en_in = en;
        start = 1'b1;
        pend = 1;
        @(posedge clk); #1;
        start = 1'b0;
        chk("R11 busy after start", 32'(busy), 32'd1);
        if (glitch) begin
            // R12: second start during busy with different inputs
            start = 1'b1;
            x_fld = ~x_fld; y_fld = ~y_fld; z_fld = ~z_fld; sched = 4'b0000;
            vf_in = ~vf; persist_in = ~ps; remap_sel_in = ~sel; remap_en_in = ~en;
            @(posedge clk); #1;
            start = 1'b0;
        end
        for (int i = 0; i < 300; i++) begin
            if (commits != c0) break;
            @(posedge clk); #1;
        end
        if (commits == c0) begin
            nchk++; nbad++;
            $display("FAIL R11 no done actual=0 expected=1");
        end
        @(posedge clk); #1;
        chk("R11 idle after done", 32'(busy), 32'd0);
        chk("R12 single commit", 32'(commits - c0), 32'd1);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) c_sh[i] = '0;
        repeat (150000) @(posedge clk);
        nchk++; nbad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        // R1 reset state
        chk("R1 done", 32'(done), 32'd0);
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 shape0", shape0, 32'd0);
        chk("R1 vl", 32'(vl), 32'd0);
        chk("R1 maxvl", 32'(maxvl), 32'd0);
        chk("R1 remap_sel_out", 32'(remap_sel_out), 32'd0);

        // R2 R3 matrix
        run(2, 3, 1, 4'b0000, 0, 0, 10'h3FF, 5'h1F, 0);
        run(4, 0, 6, 4'b0000, 1, 0, 10'h155, 5'h0A, 0);
        run(31, 31, 31, 4'b0000, 0, 0, 10'h000, 5'h00, 0);
        // R4 R5 R7 FFT
        run(7, 9, 3, 4'b0001, 0, 0, 10'h0, 5'h0, 0);
        run(31, 2, 0, 4'b0001, 1, 0, 10'h0, 5'h0, 0);
        run(0, 0, 5, 4'b0001, 0, 0, 10'h0, 5'h0, 0);
        run(5, 0, 1, 4'b0001, 0, 0, 10'h0, 5'h0, 0);
        run(30, 0, 2, 4'b0001, 0, 0, 10'h0, 5'h0, 0);
        // R6 R7 reduction
        run(31, 4, 1, 4'b0111, 0, 0, 10'h0, 5'h0, 0);
        run(0, 0, 0, 4'b0111, 0, 0, 10'h0, 5'h0, 0);
        run(6, 0, 2, 4'b0111, 1, 0, 10'h0, 5'h0, 0);
        run(12, 0, 31, 4'b0111, 0, 0, 10'h0, 5'h0, 0);
        // R8 unsupported codes
        run(3, 3, 3, 4'b0010, 0, 0, 10'h0, 5'h0, 0);
        run(9, 1, 2, 4'b1111, 1, 0, 10'h0, 5'h0, 0);
        run(9, 1, 2, 4'b0100, 0, 0, 10'h0, 5'h0, 0);
        // R9 R10 persistence keeps selectors; then clears them
        run(1, 1, 1, 4'b0000, 1, 1, 10'h2A7, 5'h13, 0);
        run(1, 1, 1, 4'b0001, 0, 1, 10'h0F0, 5'h05, 0);
        run(1, 1, 1, 4'b0000, 1, 0, 10'h2A7, 5'h13, 0);
        // R12 start while busy is ignored
        run(7, 2, 2, 4'b0111, 1, 1, 10'h111, 5'h11, 1);
        run(3, 0, 0, 4'b0001, 0, 0, 10'h222, 5'h02, 1);

        repeat (3) @(posedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
        $finish;
    end

endmodule